// File: doc/BRIEF.md
# ADC Start-of-Conversion Event Trigger

This block sits beside a PWM time base and turns its counter events into start-of-conversion pulses for an ADC. The time base supplies four single-cycle strobes: counter at zero, counter at period, counter equal to compare A while rising, and counter equal to compare A while falling. A three-bit select code picks one of these strobes as the trigger source. A two-bit prescale value sets how many selected events must pass before a pulse is issued. A global enable gates the whole path.

Each issued pulse is one clock wide. It also clears the internal event counter and sets a sticky flag that software-side logic can clear with a strobe. The event counter can be read at all times, so the progress toward the next pulse is visible. Compare values of zero need no special treatment. Such a compare strobe coincides with the zero strobe and is counted like any other selected event.

Top module: `soc_event_trigger`

## Requirements
- R1: While `trigEn` is 0, no selected event is counted, `evtCount` holds, and `socPulse` stays 0.
- R2: Select code 1 makes `zeroEvt` the trigger source.
- R3: Select code 2 makes `periodEvt` the trigger source.
- R4: Select code 4 makes `cmpUpEvt` the trigger source.
- R5: Select code 5 makes `cmpDownEvt` the trigger source.
- R6: Select codes 0, 3, 6 and 7 are reserved. Under them no strobe is counted and no pulse is issued.
- R7: With prescale N (1..3), a pulse is issued on every Nth counted event. `socPulse` is high for exactly the one cycle after the clock edge that samples that event.
- R8: Prescale 0 stops counting and pulse generation. `evtCount` holds.
- R9: `evtCount` is 0 after reset. It increments on each counted event that does not issue a pulse, and it returns to 0 on each issued pulse.
- R10: `socFlag` is 0 after reset and is set by each issued pulse. A `flagClr` strobe clears it. When a pulse and `flagClr` fall on the same edge, the flag is set.
- R11: If prescale is lowered to a value at or below `evtCount`+1, the next counted event issues a pulse.
- R12: Only the selected strobe matters. Other strobes asserted in the same cycle neither add counts nor block the selected one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| zeroEvt | input | 1 | Counter-equals-zero strobe |
| periodEvt | input | 1 | Counter-equals-period strobe |
| cmpUpEvt | input | 1 | Compare A match while counting up |
| cmpDownEvt | input | 1 | Compare A match while counting down |
| trigEn | input | 1 | Enables the trigger path |
| evtSel | input | 3 | Trigger source select code |
| prescale | input | 2 | Events per pulse, 0 disables |
| flagClr | input | 1 | One-cycle clear of the sticky flag |
| socPulse | output | 1 | One-cycle start-of-conversion pulse |
| evtCount | output | 2 | Selected events counted since the last pulse |
| socFlag | output | 1 | Sticky pulse-issued flag |

## Verification
The bench builds the block with its default two-bit prescale. This keeps the configuration space small enough to sweep every select code, every prescale value and both enable states. Within each configuration it drives every strobe line alone and in coincident groups, and it places flag clears between events. Directed sequences then cover a flag clear that lands on a pulse edge and a prescale lowered below the current count.

// File: rtl/soc_trig_pkg.sv
package soc_trig_pkg;
  localparam int SEL_W = 3;
  localparam int NUM_LINES = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_OFF   = 3'd0,
    SEL_ZERO  = 3'd1,
    SEL_PRD   = 3'd2,
    SEL_RSV3  = 3'd3,
    SEL_CMPUP = 3'd4,
    SEL_CMPDN = 3'd5,
    SEL_RSV6  = 3'd6,
    SEL_RSV7  = 3'd7
  } evtSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic countEvt;  // a selected, enabled event arrived
    logic issue;     // this event completes the prescale window
  } trigStrb_t;

  // Select code that routes strobe line idx (0 zero, 1 period, 2 cmp up, 3 cmp down).
  function automatic logic [SEL_W-1:0] lineCode(input int idx);
    case (idx)
      0:       lineCode = SEL_ZERO;
      1:       lineCode = SEL_PRD;
      2:       lineCode = SEL_CMPUP;
      default: lineCode = SEL_CMPDN;
    endcase
  endfunction
endpackage

// File: rtl/soc_trig_ctrl.sv
module soc_trig_ctrl
  import soc_trig_pkg::*;
#(
  parameter int PRE_W = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        evtLines,
  input  logic                        trigEn,
  input  logic [SEL_W-1:0]            evtSel,
  input  logic [PRE_W-1:0]            prescale,
  input  logic [PRE_W-1:0]            evtCount,
  output trigStrb_t                   strb
);
  localparam int EXT_W = PRE_W + 1;

  logic [NUM_LINES-1:0] lineHit;
  logic                 selHit;
  logic [EXT_W-1:0]     nextCnt;
  logic                 reservedSel;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
      assign lineHit[gi] = evtLines[gi] && (evtSel == lineCode(gi));
    end
  endgenerate

  assign selHit  = |lineHit;
  assign nextCnt = {1'b0, evtCount} + EXT_W'(1);

  always_comb begin
    strb.countEvt = trigEn && (prescale != '0) && selHit;
    strb.issue    = strb.countEvt && (nextCnt >= {1'b0, prescale});
  end

  always_comb begin
    case (evtSel)
      SEL_ZERO, SEL_PRD, SEL_CMPUP, SEL_CMPDN: reservedSel = 1'b0;
      default:                                 reservedSel = 1'b1;
    endcase
  end

  // R1
  trig_en_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trigEn |-> !strb.countEvt && !strb.issue);
  // R6
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    reservedSel |-> !strb.countEvt);
  // R8
  zero_prescale_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prescale == '0) |-> !strb.issue);
  // R12
  no_line_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtLines == '0) |-> !strb.countEvt);
endmodule

// File: rtl/soc_trig_datapath.sv
module soc_trig_datapath
  import soc_trig_pkg::*;
#(
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  trigStrb_t        strb,
  input  logic             flagClr,
  output logic             socPulse,
  output logic [PRE_W-1:0] evtCount,
  output logic             socFlag
);
  logic [PRE_W-1:0] cntQ;
  logic             pulseQ;
  logic             flagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      pulseQ <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      pulseQ <= strb.issue;
      if (strb.issue)         cntQ <= '0;
      else if (strb.countEvt) cntQ <= cntQ + PRE_W'(1);
      if (strb.issue)         flagQ <= 1'b1;
      else if (flagClr)       flagQ <= 1'b0;
    end
  end

  assign socPulse = pulseQ;
  assign evtCount = cntQ;
  assign socFlag  = flagQ;

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |-> (cntQ == '0));
  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.countEvt |=> $stable(cntQ));
  // R10
  flag_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |-> flagQ);
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagClr && !strb.issue |=> !flagQ);
  // R7
  pulse_needs_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.countEvt |=> !pulseQ);
endmodule

// File: rtl/soc_event_trigger.sv
module soc_event_trigger
  import soc_trig_pkg::*;
#(
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             zeroEvt,
  input  logic             periodEvt,
  input  logic             cmpUpEvt,
  input  logic             cmpDownEvt,
  input  logic             trigEn,
  input  logic [2:0]       evtSel,
  input  logic [PRE_W-1:0] prescale,
  input  logic             flagClr,
  output logic             socPulse,
  output logic [PRE_W-1:0] evtCount,
  output logic             socFlag
);
  trigStrb_t            strb;
  logic [NUM_LINES-1:0] evtLines;

  assign evtLines = {cmpDownEvt, cmpUpEvt, periodEvt, zeroEvt};

  soc_trig_ctrl #(.PRE_W(PRE_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evtLines (evtLines),
    .trigEn   (trigEn),
    .evtSel   (evtSel),
    .prescale (prescale),
    .evtCount (evtCount),
    .strb     (strb)
  );

  soc_trig_datapath #(.PRE_W(PRE_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .flagClr  (flagClr),
    .socPulse (socPulse),
    .evtCount (evtCount),
    .socFlag  (socFlag)
  );
endmodule

// File: tb/test_soc_event_trigger.sv
module test_soc_event_trigger;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, zeroEvt, periodEvt, cmpUpEvt, cmpDownEvt, trigEn, flagClr;
  logic [2:0] evtSel;
  logic [1:0] prescale;
  logic       socPulse, socFlag;
  logic [1:0] evtCount;

  soc_event_trigger i_soc_event_trigger (
    .clk(clk), .rstN(rstN), .zeroEvt(zeroEvt), .periodEvt(periodEvt),
    .cmpUpEvt(cmpUpEvt), .cmpDownEvt(cmpDownEvt), .trigEn(trigEn),
    .evtSel(evtSel), .prescale(prescale), .flagClr(flagClr),
    .socPulse(socPulse), .evtCount(evtCount), .socFlag(socFlag)
  );

  int checks = 0;
  int errors = 0;
  int mCnt   = 0;
  bit mFlag  = 0;
  bit mPulse = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string pulseTag();
    if (!trigEn)                    return "R1";
    if (prescale == 2'd0)           return "R8";
    case (evtSel)
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd4:    return "R4";
      3'd5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  // Called at a negedge; drives, clocks, updates the model, compares at next negedge.
  task automatic step(input bit z, input bit p, input bit u, input bit d,
                      input bit clr, input string tag);
    bit sel, hit;
    zeroEvt = z; periodEvt = p; cmpUpEvt = u; cmpDownEvt = d; flagClr = clr;
    case (evtSel)
      3'd1:    sel = z;
      3'd2:    sel = p;
      3'd4:    sel = u;
      3'd5:    sel = d;
      default: sel = 1'b0;
    endcase
    hit = trigEn && (prescale != 2'd0) && sel;
    @(posedge clk);
    mPulse = 1'b0;
    if (hit) begin
      if (mCnt + 1 >= int'(prescale)) begin
        mPulse = 1'b1; mCnt = 0; mFlag = 1'b1;
      end else begin
        mCnt = mCnt + 1;
      end
    end
    if (clr && !mPulse) mFlag = 1'b0;
    @(negedge clk);
    chk(tag, int'(socPulse), int'(mPulse));
    chk("R9 count", int'(evtCount), mCnt);
    chk("R10 flag", int'(socFlag), int'(mFlag));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    zeroEvt = 0; periodEvt = 0; cmpUpEvt = 0; cmpDownEvt = 0; flagClr = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mCnt = 0; mFlag = 0; mPulse = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    trigEn = 0; evtSel = 0; prescale = 0;
    doReset();
    // R9 R10 reset state
    chk("R9 reset count", int'(evtCount), 0);
    chk("R10 reset flag", int'(socFlag), 0);
    chk("R7 reset pulse", int'(socPulse), 0);

    // Sweep: select x prescale x enable.
    for (int s = 0; s < 8; s++) begin
      for (int ps = 0; ps < 4; ps++) begin
        for (int e = 0; e < 2; e++) begin
          evtSel = 3'(s); prescale = 2'(ps); trigEn = 1'(e);
          doReset();
          for (int r = 0; r < 3; r++) begin
            step(1, 0, 0, 0, 0, pulseTag());
            step(0, 1, 0, 0, 0, pulseTag());
            step(0, 0, 1, 0, 0, pulseTag());
            step(0, 0, 0, 1, 0, pulseTag());
          end
          // R12 coincident strobes (compare value 0 meets zero)
          step(1, 1, 1, 1, 0, "R12");
          step(1, 0, 1, 0, 0, "R12");
          step(0, 0, 0, 0, 1, "R10");
          step(0, 0, 0, 0, 0, pulseTag());
        end
      end
    end

    // R10: clear strobe on the same edge as a pulse; set wins.
    evtSel = 3'd1; prescale = 2'd1; trigEn = 1;
    doReset();
    step(1, 0, 0, 0, 1, "R10 set-wins pulse");
    chk("R10 set wins", int'(socFlag), 1);
    step(0, 0, 0, 0, 1, "R10 clear");
    chk("R10 cleared", int'(socFlag), 0);

    // R7: prescale 2 on period events, pulses every second event.
    evtSel = 3'd2; prescale = 2'd2;
    doReset();
    for (int k = 0; k < 6; k++) step(0, 1, 0, 0, 0, "R7");

    // R11: lower prescale below the current count.
    evtSel = 3'd4; prescale = 2'd3;
    doReset();
    step(0, 0, 1, 0, 0, "R11");
    step(0, 0, 1, 0, 0, "R11");
    chk("R11 count before", int'(evtCount), 2);
    prescale = 2'd1;
    step(0, 0, 0, 0, 0, "R11 idle");
    chk("R11 hold", int'(evtCount), 2);
    step(0, 0, 1, 0, 0, "R11 fire");
    chk("R11 pulse", int'(socPulse), 1);
    chk("R11 count after", int'(evtCount), 0);

    // R8: prescale 0 holds a non-zero count.
    prescale = 2'd3;
    step(0, 0, 1, 0, 0, "R8 prep");
    prescale = 2'd0;
    step(0, 0, 1, 0, 0, "R8");
    chk("R8 held count", int'(evtCount), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule